// File: doc/BRIEF.md
# Boot Address Remap Controller

This block sits on the system bus in front of the region decoder. It lets boot ROM, user flash or an SRAM block appear in a small window that starts at address zero. The processor fetches its initial stack pointer and its reset vector from the bottom of the map, so a valid image must be visible there from the first cycle after reset. For that reason the controller comes out of reset with the boot ROM aliased into the window.

The boot code later writes a two-bit remap register through a single-cycle write port. That write moves either user flash or SRAM into the window. Mapping SRAM there lets code and vector fetches avoid flash wait states. Every memory also stays reachable at its own fixed base, whatever the mode.

Each address phase (`bus_valid` high) is registered. One clock later the block presents the translated address and a target select. A remap write never changes a transfer whose address phase is already under way. It affects only address phases that begin after the write cycle.

Top module: `zero_alias_remap`

## Requirements
- R1: After reset the remap register holds 2'b00 (boot mode). In boot mode an address below 2^WIN_BITS is sent to ROM_BASE plus that address, with target select 2'b01 (boot ROM).
- R2: In mode 2'b01 a window address is sent to FLASH_BASE plus the address, with target select 2'b10 (flash).
- R3: In mode 2'b10 a window address is sent to SRAM_BASE plus the address, with target select 2'b11 (SRAM).
- R4: Mode 2'b11 behaves exactly like mode 2'b01: window addresses go to flash with select 2'b10.
- R5: An address at or above 2^WIN_BITS passes through unchanged, in every mode.
- R6: Outside the window, the target select comes from the fixed map, in every mode. An address whose upper bits (above REG_BITS) match ROM_BASE, FLASH_BASE or SRAM_BASE gets select 2'b01, 2'b10 or 2'b11 respectively. Any other address gets 2'b00.
- R7: A write to the register in the same cycle as an address phase does not affect that transfer. The transfer uses the old mode, and the next address phase uses the new one.
- R8: `out_valid` is high exactly one cycle after a cycle with `bus_valid` high, and low otherwise. It is low during and right after reset.
- R9: Address 2^WIN_BITS-1 is translated and address 2^WIN_BITS is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the remap register |
| cfg_wr_data | input | 2 | New remap mode |
| bus_valid | input | 1 | Address phase present this cycle |
| bus_addr | input | AW | Incoming bus address |
| out_valid | output | 1 | Translated transfer present |
| out_addr | output | AW | Translated address |
| out_sel | output | 2 | Target: 00 none, 01 boot ROM, 10 flash, 11 SRAM |

## Verification
The assertions assume that `bus_valid` and `cfg_wr_en` are low while reset is asserted. They also assume that the three memory bases are aligned to 2^REG_BITS and lie above the alias window. The stimulus holds every input at zero through reset and uses the default, aligned bases. Random address phases are drawn from the window, from the three fixed regions and from the full address space. Random writes to the remap register are mixed in, some landing in the same cycle as an address phase.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;
  typedef enum logic [1:0] {
    MAP_BOOT      = 2'b00,
    MAP_FLASH     = 2'b01,
    MAP_SRAM      = 2'b10,
    MAP_FLASH_ALT = 2'b11
  } map_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_ROM   = 2'b01,
    TGT_FLASH = 2'b10,
    TGT_SRAM  = 2'b11
  } target_e;

  // Memory placed in the zero window for a given register value
  function automatic target_e mode_target(input logic [1:0] mode);
    case (mode)
      MAP_BOOT: return TGT_ROM;
      MAP_SRAM: return TGT_SRAM;
      default:  return TGT_FLASH;
    endcase
  endfunction
endpackage

// File: rtl/remap_mode_reg.sv
`timescale 1ns/1ps
module remap_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] mode_q
);
  import remap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MAP_BOOT;
    else if (wr_en) mode_q <= wr_data;
  end
endmodule

// File: rtl/remap_xlate.sv
`timescale 1ns/1ps
module remap_xlate #(
  parameter int AW = 32,
  parameter int WIN_BITS = 12,
  parameter int REG_BITS = 16,
  parameter logic [AW-1:0] ROM_BASE   = 32'h1FFF_0000,
  parameter logic [AW-1:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] SRAM_BASE  = 32'h2000_0000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    sel_o,
  output logic          in_window_o
);
  import remap_pkg::*;

  localparam int NREG = 3;
  localparam logic [AW-1:0] REG_BASE [NREG] = '{ROM_BASE, FLASH_BASE, SRAM_BASE};
  localparam target_e       REG_TGT  [NREG] = '{TGT_ROM, TGT_FLASH, TGT_SRAM};

  // Window offset grafted onto an aligned base
  function automatic logic [AW-1:0] alias_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] a);
    return {base[AW-1:WIN_BITS], a[WIN_BITS-1:0]};
  endfunction

  logic [NREG-1:0] reg_hit;
  target_e         win_tgt;
  target_e         sel_t;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    assign reg_hit[g] = (addr_i[AW-1:REG_BITS] == REG_BASE[g][AW-1:REG_BITS]);
  end

  assign in_window_o = (addr_i[AW-1:WIN_BITS] == '0);
  assign win_tgt     = mode_target(mode_i);

  always_comb begin
    addr_o = addr_i;
    sel_t  = TGT_NONE;
    if (in_window_o) begin
      sel_t = win_tgt;
      case (win_tgt)
        TGT_ROM:  addr_o = alias_addr(ROM_BASE, addr_i);
        TGT_SRAM: addr_o = alias_addr(SRAM_BASE, addr_i);
        default:  addr_o = alias_addr(FLASH_BASE, addr_i);
      endcase
    end else begin
      for (int i = 0; i < NREG; i++)
        if (reg_hit[i]) sel_t = REG_TGT[i];
    end
  end

  assign sel_o = sel_t;
endmodule

// File: rtl/remap_out_stage.sv
`timescale 1ns/1ps
module remap_out_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    sel_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      sel_o   <= 2'b00;
    end else begin
      valid_o <= load;
      if (load) begin
        addr_o <= addr_i;
        sel_o  <= sel_i;
      end
    end
  end
endmodule

// File: rtl/zero_alias_remap.sv
`timescale 1ns/1ps
module zero_alias_remap #(
  parameter int AW = 32,
  parameter int WIN_BITS = 12,
  parameter int REG_BITS = 16,
  parameter logic [AW-1:0] ROM_BASE   = 32'h1FFF_0000,
  parameter logic [AW-1:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] SRAM_BASE  = 32'h2000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_wr_data,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_sel
);
  logic [1:0]    mode_q;
  logic [AW-1:0] xl_addr;
  logic [1:0]    xl_sel;
  logic          xl_in_window;

  remap_mode_reg mode_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
    .wr_data(cfg_wr_data), .mode_q(mode_q)
  );

  remap_xlate #(
    .AW(AW), .WIN_BITS(WIN_BITS), .REG_BITS(REG_BITS),
    .ROM_BASE(ROM_BASE), .FLASH_BASE(FLASH_BASE), .SRAM_BASE(SRAM_BASE)
  ) xlate_i (
    .addr_i(bus_addr), .mode_i(mode_q), .addr_o(xl_addr),
    .sel_o(xl_sel), .in_window_o(xl_in_window)
  );

  remap_out_stage #(.AW(AW)) out_i (
    .clk(clk), .rst_n(rst_n), .load(bus_valid), .addr_i(xl_addr),
    .sel_i(xl_sel), .valid_o(out_valid), .addr_o(out_addr), .sel_o(out_sel)
  );
endmodule

// File: rtl/zero_alias_remap_chk.sv
`timescale 1ns/1ps
module zero_alias_remap_chk #(
  parameter int AW = 32,
  parameter int WIN_BITS = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic [1:0]    cfg_wr_data,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    mode_q,
  input logic          xl_in_window,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic [1:0]    out_sel
);
  // R1: register keeps its value without a write
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(mode_q));

  // R7: a write lands on the following edge
  p_mode_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> mode_q == $past(cfg_wr_data));

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> out_valid);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !out_valid);

  p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !xl_in_window |=> out_addr == $past(bus_addr));

  p_boot_alias_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && xl_in_window && mode_q == 2'b00 |=>
      out_sel == 2'b01 && out_addr[WIN_BITS-1:0] == $past(bus_addr[WIN_BITS-1:0]));

  p_sram_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && xl_in_window && mode_q == 2'b10 |=> out_sel == 2'b11);

  p_flash_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && xl_in_window && mode_q[0] |=> out_sel == 2'b10);
endmodule

bind zero_alias_remap zero_alias_remap_chk #(.AW(AW), .WIN_BITS(WIN_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .mode_q(mode_q),
  .xl_in_window(xl_in_window), .out_valid(out_valid), .out_addr(out_addr),
  .out_sel(out_sel)
);

// File: tb/zero_alias_remap_tb_top.sv
`timescale 1ns/1ps
module zero_alias_remap_tb_top;
  localparam logic [31:0] WIN     = 32'h0000_1000;
  localparam logic [31:0] RSIZE   = 32'h0001_0000;
  localparam logic [31:0] ROM_B   = 32'h1FFF_0000;
  localparam logic [31:0] FLASH_B = 32'h0800_0000;
  localparam logic [31:0] SRAM_B  = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_data = 2'b00;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [1:0]  out_sel;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [1:0] model_mode = 2'b00;

  always #2.5 clk = ~clk;

  zero_alias_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_sel(out_sel)
  );

  function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] a);
    if (a < WIN) begin
      if (m == 2'b00) return ROM_B + a;
      if (m == 2'b10) return SRAM_B + a;
      return FLASH_B + a;
    end
    return a;
  endfunction

  function automatic logic [1:0] exp_sel(input logic [1:0] m, input logic [31:0] a);
    if (a < WIN) return (m == 2'b00) ? 2'b01 : (m == 2'b10) ? 2'b11 : 2'b10;
    if (a >= ROM_B   && a - ROM_B   < RSIZE) return 2'b01;
    if (a >= FLASH_B && a - FLASH_B < RSIZE) return 2'b10;
    if (a >= SRAM_B  && a - SRAM_B  < RSIZE) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check the registered result one cycle later
  task automatic step(input bit wr, input logic [1:0] wd, input bit v,
                      input logic [31:0] a, input string req);
    logic [1:0] m_before;
    m_before    = model_mode;
    cfg_wr_en   = wr;
    cfg_wr_data = wd;
    bus_valid   = v;
    bus_addr    = a;
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, {31'b0, out_valid}, {31'b0, v});
    if (v) begin
      check({req, " addr"}, out_addr, exp_addr(m_before, a));
      check({req, " sel"}, {30'b0, out_sel}, {30'b0, exp_sel(m_before, a)});
    end
    if (wr) model_mode = wd;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    repeat (4) @(negedge clk);
    check("R8 reset valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 post reset valid", {31'b0, out_valid}, 32'd0);

    step(0, 2'b00, 1, 32'h0000_0000, "R1 boot zero");
    step(0, 2'b00, 1, 32'h0000_0004, "R1 boot vector");
    step(0, 2'b00, 1, WIN - 1, "R9 last window");
    step(0, 2'b00, 1, WIN, "R9 first outside");
    step(0, 2'b00, 0, 32'h0000_0008, "R8 idle");
    // write in the same cycle as a transfer: old mode applies
    step(1, 2'b01, 1, 32'h0000_0010, "R7 same cycle");
    step(0, 2'b00, 1, 32'h0000_0010, "R2 flash alias");
    step(0, 2'b00, 1, ROM_B + 32'h20, "R6 rom fixed");
    step(0, 2'b00, 1, SRAM_B + 32'h40, "R6 sram fixed");
    step(0, 2'b00, 1, 32'h7000_0000, "R6 unmapped");
    step(0, 2'b00, 1, 32'h0000_2000, "R5 pass");
    step(1, 2'b10, 0, 32'h0, "R3 write");
    step(0, 2'b00, 1, 32'h0000_0FFC, "R3 sram alias");
    step(1, 2'b11, 1, 32'h0000_0100, "R7 old sram");
    step(0, 2'b00, 1, 32'h0000_0100, "R4 alt flash");
    step(1, 2'b00, 0, 32'h0, "R1 back to boot");
    step(0, 2'b00, 1, 32'h0000_0044, "R1 boot again");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      bit wr, v;
      case ($urandom % 5)
        0: a = $urandom % WIN;
        1: a = ROM_B + ($urandom % RSIZE);
        2: a = FLASH_B + ($urandom % RSIZE);
        3: a = SRAM_B + ($urandom % RSIZE);
        default: a = $urandom;
      endcase
      wr = ($urandom % 4) == 0;
      v  = ($urandom % 8) != 0;
      step(wr, 2'($urandom), v, a, "R5 R6 random");
    end

    cfg_wr_en = 1'b0;
    bus_valid = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule